// File: doc/BRIEF.md
# Serialized L1 Invalidation Walker

This block serves a compute unit that needs every line of its small L1 data cache dropped before it goes on, for example at a synchronization point. A cache-wide invalidate arrives on a request port. The block accepts it only if no other invalidate is still open. It then steps through each line index of the cache and reads the tag array to get the address held at that index. For every line it sends one eviction request downstream.

Each accepted eviction adds one to a count of outstanding acknowledgements, and each acknowledgement takes one away. The requester gets a single completion pulse only when two things are true: the walk has visited the last index, and the count has fallen back to zero. A second invalidate that arrives while one is open is turned away with a retry indication, so invalidations are strictly serialized. Ordinary requests share the request port. A parameter chooses whether they are held off while a walk is in progress.

Top module: `l1_inval_walker`

## Requirements
- R1: While an invalidate is pending, a request with `req_is_inval`=1 sees `req_ready`=0 and `req_retry`=1 in the same cycle, and it starts no second walk.
- R2: With no invalidate pending, an invalidate request sees `req_ready`=1. The walk visits indices 0 through NUM_LINES-1 in ascending order and issues exactly NUM_LINES evictions. No eviction is ever offered while no invalidate is pending.
- R3: Each eviction carries the address that `tag_rd_addr` returned in the cycle when `tag_rd_en` was high for that index. The tag read is combinational.
- R4: While `evict_valid`=1 and `evict_ready`=0, the next cycle still shows `evict_valid`=1 with the same `evict_addr`. The walk advances only on an accepted handshake.
- R5: The outstanding count rises by one per accepted eviction and falls by one per valid acknowledgement. If both happen in one cycle, the count does not change. Completion never comes before every issued eviction has been acknowledged, even if the acknowledgements catch up with the walk part way through.
- R6: `inv_done` is a one-cycle pulse, given exactly once per invalidate. It appears in the cycle after the acknowledgement that brings the count to zero, provided the last index has been issued. In that same cycle the invalidate stops being pending.
- R7: An acknowledgement that arrives with no invalidate pending, or with the count at zero, sets `inv_err`. The flag stays set until reset, and that acknowledgement changes nothing else.
- R8: With no invalidate pending, a normal request (`req_is_inval`=0) sees `req_ready`=1 and `req_retry`=0. While one is pending and BLOCK_NORMAL=1 (the default), it sees `req_ready`=0 and `req_retry`=0.
- R9: Coming out of reset, `evict_valid`, `tag_rd_en`, `inv_done` and `inv_err` are 0, and nothing is pending.
- R10: After a completion pulse, a fresh invalidate is accepted and walks the whole cache again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_is_inval | input | 1 | 1 = cache-wide invalidate, 0 = normal access |
| req_ready | output | 1 | Request accepted this cycle |
| req_retry | output | 1 | Invalidate refused; requester must resend later |
| tag_rd_en | output | 1 | Tag array read strobe |
| tag_rd_idx | output | IDX_W | Line index being read |
| tag_rd_addr | input | ADDR_W | Address stored at `tag_rd_idx` (same-cycle return) |
| evict_valid | output | 1 | Eviction request offered downstream |
| evict_ready | input | 1 | Downstream takes the eviction |
| evict_addr | output | ADDR_W | Line address to evict |
| inv_ack | input | 1 | One eviction acknowledged |
| inv_done | output | 1 | Invalidate complete (one-cycle pulse) |
| inv_err | output | 1 | Sticky flag for an unexpected acknowledgement |

## Verification
The assertions assume that the tag array returns its data in the same cycle as the read, and that downstream sends an acknowledgement only for an eviction it has already taken. The bench's downstream model keeps to this: it counts handshakes completed at earlier edges and never acknowledges more than that count. The one exception is a deliberate stray acknowledgement sent while idle, used to check the sticky error. Inputs change only at the falling edge. Different acknowledgement timings (immediate, deferred to the end, sparse) and backpressure patterns move the point at which the count reaches zero relative to the end of the walk.

// File: rtl/inval_walk_pkg.sv
package inval_walk_pkg;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_READ  = 2'd1,
        WK_ISSUE = 2'd2
    } walk_state_e;

    function automatic int unsigned idx_width(input int unsigned lines);
        return (lines > 1) ? $clog2(lines) : 1;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned lines);
        return $clog2(lines + 1);
    endfunction

endpackage

// File: rtl/inval_req_gate.sv
module inval_req_gate #(
    parameter bit BLOCK_NORMAL = 1'b1
) (
    input  logic req_valid,
    input  logic req_is_inval,
    input  logic busy,
    output logic req_ready,
    output logic req_retry,
    output logic inval_accept
);

    logic normal_ok;

    always_comb begin
        normal_ok = !busy || !BLOCK_NORMAL;
        if (req_is_inval) begin
            req_ready = !busy;
        end else begin
            req_ready = normal_ok;
        end
        req_retry    = req_valid && req_is_inval && busy;
        inval_accept = req_valid && req_is_inval && !busy;
    end

endmodule

// File: rtl/inval_line_walker.sv
module inval_line_walker
    import inval_walk_pkg::*;
#(
    parameter int unsigned NUM_LINES = 16,
    parameter int unsigned ADDR_W    = 32,
    localparam int unsigned IDX_W    = idx_width(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              tag_rd_en,
    output logic [IDX_W-1:0]  tag_rd_idx,
    input  logic [ADDR_W-1:0] tag_rd_addr,
    output logic              evict_valid,
    input  logic              evict_ready,
    output logic [ADDR_W-1:0] evict_addr,
    output logic              issue_fire,
    output logic              last_fire
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

    typedef struct packed {
        walk_state_e       state;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
    } walk_t;

    walk_t wk_d, wk_q;

    always_comb begin
        wk_d        = wk_q;
        tag_rd_en   = 1'b0;
        evict_valid = 1'b0;
        issue_fire  = 1'b0;
        last_fire   = 1'b0;
        unique case (wk_q.state)
            WK_IDLE: begin
                if (start) begin
                    wk_d.idx   = '0;
                    wk_d.state = WK_READ;
                end
            end
            WK_READ: begin
                tag_rd_en  = 1'b1;
                wk_d.addr  = tag_rd_addr;
                wk_d.state = WK_ISSUE;
            end
            WK_ISSUE: begin
                evict_valid = 1'b1;
                if (evict_ready) begin
                    issue_fire = 1'b1;
                    if (wk_q.idx == LAST_IDX) begin
                        last_fire  = 1'b1;
                        wk_d.state = WK_IDLE;
                    end else begin
                        wk_d.idx   = wk_q.idx + 1'b1;
                        wk_d.state = WK_READ;
                    end
                end
            end
            default: wk_d.state = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wk_q.state <= WK_IDLE;
            wk_q.idx   <= '0;
            wk_q.addr  <= '0;
        end else begin
            wk_q <= wk_d;
        end
    end

    assign tag_rd_idx = wk_q.idx;
    assign evict_addr = wk_q.addr;

endmodule

// File: rtl/inval_ack_tracker.sv
module inval_ack_tracker
    import inval_walk_pkg::*;
#(
    parameter int unsigned NUM_LINES = 16,
    localparam int unsigned CNT_W    = cnt_width(NUM_LINES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic issue_fire,
    input  logic inv_ack,
    output logic cnt_zero,
    output logic cnt_zero_next,
    output logic err
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             err;
    } trk_t;

    trk_t trk_d, trk_q;
    logic bad_ack;
    logic good_ack;

    always_comb begin
        trk_d    = trk_q;
        bad_ack  = inv_ack && (!busy || (trk_q.cnt == '0));
        good_ack = inv_ack && !bad_ack;
        if (issue_fire && !good_ack) begin
            trk_d.cnt = trk_q.cnt + 1'b1;
        end else if (!issue_fire && good_ack) begin
            trk_d.cnt = trk_q.cnt - 1'b1;
        end
        if (bad_ack) begin
            trk_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q.cnt <= '0;
            trk_q.err <= 1'b0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign cnt_zero      = (trk_q.cnt == '0);
    assign cnt_zero_next = (trk_d.cnt == '0);
    assign err           = trk_q.err;

endmodule

// File: rtl/l1_inval_walker.sv
module l1_inval_walker
    import inval_walk_pkg::*;
#(
    parameter int unsigned NUM_LINES    = 16,
    parameter int unsigned ADDR_W       = 32,
    parameter bit          BLOCK_NORMAL = 1'b1,
    localparam int unsigned IDX_W       = idx_width(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_inval,
    output logic              req_ready,
    output logic              req_retry,
    output logic              tag_rd_en,
    output logic [IDX_W-1:0]  tag_rd_idx,
    input  logic [ADDR_W-1:0] tag_rd_addr,
    output logic              evict_valid,
    input  logic              evict_ready,
    output logic [ADDR_W-1:0] evict_addr,
    input  logic              inv_ack,
    output logic              inv_done,
    output logic              inv_err
);

    typedef struct packed {
        logic pending;
        logic walked_all;
        logic done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic busy;
    logic inval_accept;
    logic issue_fire;
    logic last_fire;
    logic cnt_zero;
    logic cnt_zero_next;

    assign busy = ctl_q.pending;

    inval_req_gate #(
        .BLOCK_NORMAL(BLOCK_NORMAL)
    ) u_gate (
        .req_valid    (req_valid),
        .req_is_inval (req_is_inval),
        .busy         (busy),
        .req_ready    (req_ready),
        .req_retry    (req_retry),
        .inval_accept (inval_accept)
    );

    inval_line_walker #(
        .NUM_LINES(NUM_LINES),
        .ADDR_W   (ADDR_W)
    ) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (inval_accept),
        .tag_rd_en   (tag_rd_en),
        .tag_rd_idx  (tag_rd_idx),
        .tag_rd_addr (tag_rd_addr),
        .evict_valid (evict_valid),
        .evict_ready (evict_ready),
        .evict_addr  (evict_addr),
        .issue_fire  (issue_fire),
        .last_fire   (last_fire)
    );

    inval_ack_tracker #(
        .NUM_LINES(NUM_LINES)
    ) u_trk (
        .clk           (clk),
        .rst_n         (rst_n),
        .busy          (busy),
        .issue_fire    (issue_fire),
        .inv_ack       (inv_ack),
        .cnt_zero      (cnt_zero),
        .cnt_zero_next (cnt_zero_next),
        .err           (inv_err)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = ctl_q.pending && ctl_q.walked_all && cnt_zero_next;
        if (inval_accept) begin
            ctl_d.pending    = 1'b1;
            ctl_d.walked_all = 1'b0;
        end else if (ctl_d.done) begin
            ctl_d.pending    = 1'b0;
            ctl_d.walked_all = 1'b0;
        end else if (last_fire) begin
            ctl_d.walked_all = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.pending    <= 1'b0;
            ctl_q.walked_all <= 1'b0;
            ctl_q.done       <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign inv_done = ctl_q.done;

endmodule

// File: rtl/inval_walk_chk.sv
module inval_walk_chk #(
    parameter int unsigned ADDR_W       = 32,
    parameter bit          BLOCK_NORMAL = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_is_inval,
    input logic              req_ready,
    input logic              req_retry,
    input logic              evict_valid,
    input logic              evict_ready,
    input logic [ADDR_W-1:0] evict_addr,
    input logic              inv_ack,
    input logic              inv_done,
    input logic              inv_err,
    input logic              busy,
    input logic              cnt_zero
);

    AST_RETRY_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && req_valid && req_is_inval |-> req_retry && !req_ready); // R1

    AST_NO_EVICT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !evict_valid); // R2

    AST_EVICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid && !evict_ready |=> evict_valid && $stable(evict_addr)); // R4

    AST_DONE_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        inv_done |-> cnt_zero); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        inv_done |=> !inv_done); // R6

    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        inv_done |-> !busy); // R6

    AST_BAD_ACK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        inv_ack && (!busy || cnt_zero) |=> inv_err); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        inv_err |=> inv_err); // R7

    generate
        if (BLOCK_NORMAL) begin : g_blk
            AST_NORMAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
                busy && req_valid && !req_is_inval |-> !req_ready && !req_retry); // R8
        end
    endgenerate

endmodule

bind l1_inval_walker inval_walk_chk #(
    .ADDR_W      (ADDR_W),
    .BLOCK_NORMAL(BLOCK_NORMAL)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_is_inval (req_is_inval),
    .req_ready    (req_ready),
    .req_retry    (req_retry),
    .evict_valid  (evict_valid),
    .evict_ready  (evict_ready),
    .evict_addr   (evict_addr),
    .inv_ack      (inv_ack),
    .inv_done     (inv_done),
    .inv_err      (inv_err),
    .busy         (busy),
    .cnt_zero     (cnt_zero)
);

// File: tb/tb_l1_inval_walker.sv
`timescale 1ns/1ps
module tb_l1_inval_walker;

    localparam int unsigned N  = 16;
    localparam int unsigned AW = 32;
    localparam int unsigned IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_is_inval = 1'b0;
    logic          req_ready;
    logic          req_retry;
    logic          tag_rd_en;
    logic [IW-1:0] tag_rd_idx;
    logic [AW-1:0] tag_rd_addr;
    logic          evict_valid;
    logic          evict_ready = 1'b0;
    logic [AW-1:0] evict_addr;
    logic          inv_ack = 1'b0;
    logic          inv_done;
    logic          inv_err;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    function automatic logic [AW-1:0] line_addr(input int i);
        return 32'h8000_0000 + 32'(i) * 32'h40 + 32'(i * 3);
    endfunction

    assign tag_rd_addr = line_addr(int'(tag_rd_idx));

    l1_inval_walker #(.NUM_LINES(N), .ADDR_W(AW), .BLOCK_NORMAL(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_inval(req_is_inval),
        .req_ready(req_ready), .req_retry(req_retry), .tag_rd_en(tag_rd_en),
        .tag_rd_idx(tag_rd_idx), .tag_rd_addr(tag_rd_addr), .evict_valid(evict_valid),
        .evict_ready(evict_ready), .evict_addr(evict_addr), .inv_ack(inv_ack),
        .inv_done(inv_done), .inv_err(inv_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        req_valid = 1'b0; evict_ready = 1'b0; inv_ack = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R9: outputs right after reset
    task automatic t_reset();
        do_reset();
        check(!evict_valid, "R9", "evict_valid", longint'(evict_valid), 0);
        check(!tag_rd_en,   "R9", "tag_rd_en",   longint'(tag_rd_en), 0);
        check(!inv_done,    "R9", "inv_done",    longint'(inv_done), 0);
        check(!inv_err,     "R9", "inv_err",     longint'(inv_err), 0);
    endtask

    // R8: normal request while idle
    task automatic t_idle_normal();
        @(negedge clk);
        req_valid = 1'b1; req_is_inval = 1'b0;
        #1;
        check(req_ready && !req_retry, "R8", "idle normal ready/retry",
              longint'({req_ready, req_retry}), 2);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // R2 R3 R4 R5 R6 (R1 R8 when poke): one full invalidate
    task automatic t_walk(input int ack_mode, input int stall_mode, input bit poke);
        int  issued = 0, acked = 0, next_idx = 0, done_cnt = 0, after = 0;
        bit  hs_prev = 0, final_prev = 0, stall_prev = 0;
        bit  addr_ok = 1, hold_ok = 1, on_time = 1, stray = 0;
        logic [AW-1:0] prev_addr = '0;
        @(negedge clk);
        req_valid = 1'b1; req_is_inval = 1'b1;
        #1;
        check(req_ready && !req_retry, "R2", "invalidate accepted",
              longint'({req_ready, req_retry}), 2);
        for (int cyc = 0; cyc < 2000; cyc++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (hs_prev) issued++;
            if (inv_done) begin
                done_cnt++;
                if (!final_prev) on_time = 0;
            end else if (final_prev) begin
                on_time = 0;
            end
            if (done_cnt > 0 && evict_valid) stray = 1;
            if (stall_prev && !(evict_valid && evict_addr == prev_addr)) hold_ok = 0;
            if (evict_valid && evict_addr != line_addr(next_idx)) addr_ok = 0;
            if (poke && cyc == 3) begin
                req_valid = 1'b1; req_is_inval = 1'b1;
                #1;
                check(!req_ready && req_retry, "R1", "second invalidate refused",
                      longint'({req_ready, req_retry}), 1);
            end
            if (poke && cyc == 6) begin
                req_valid = 1'b1; req_is_inval = 1'b0;
                #1;
                check(!req_ready && !req_retry, "R8", "normal held while busy",
                      longint'({req_ready, req_retry}), 0);
            end
            begin
                bit go;
                case (ack_mode)
                    0: go = (issued > acked);
                    1: go = (issued == int'(N)) && (issued > acked);
                    default: go = (issued > acked) && (cyc % 3 == 0);
                endcase
                inv_ack = go;
                if (go) acked++;
                final_prev = go && (acked == int'(N));
            end
            begin
                bit rdy;
                case (stall_mode)
                    0: rdy = 1'b1;
                    1: rdy = (cyc % 2 == 1);
                    default: rdy = (cyc % 4 == 3);
                endcase
                evict_ready = rdy;
                hs_prev    = rdy && evict_valid;
                stall_prev = evict_valid && !rdy;
                prev_addr  = evict_addr;
                if (hs_prev) next_idx++;
            end
            if (done_cnt > 0) after++;
            if (after >= 4) break;
        end
        inv_ack = 1'b0; evict_ready = 1'b0; req_valid = 1'b0;
        check(issued == int'(N) && next_idx == int'(N), "R2", "evictions issued",
              longint'(issued), longint'(N));
        check(addr_ok, "R3", "eviction addresses", 0, 1);
        check(hold_ok, "R4", "held under backpressure", 0, 1);
        check(on_time, "R5", "done only after final ack", 0, 1);
        check(done_cnt == 1, "R6", "done pulse count", longint'(done_cnt), 1);
        check(!stray, "R2", "no eviction after done", longint'(stray), 0);
        check(!inv_err, "R7", "no error on legal acks", longint'(inv_err), 0);
    endtask

    // R7: stray ack when idle
    task automatic t_stray_ack();
        do_reset();
        @(negedge clk); inv_ack = 1'b1;
        @(negedge clk); inv_ack = 1'b0;
        check(inv_err, "R7", "error on stray ack", longint'(inv_err), 1);
        check(!inv_done, "R7", "stray ack gives no done", longint'(inv_done), 0);
        repeat (3) @(negedge clk);
        check(inv_err, "R7", "error sticky", longint'(inv_err), 1);
        do_reset();
        check(!inv_err, "R9", "reset clears error", longint'(inv_err), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_idle_normal();
        t_walk(0, 0, 1'b1);   // acks chase the walk, simultaneous issue/ack
        t_walk(1, 1, 1'b0);   // R10 back-to-back, acks deferred, stalls
        t_walk(2, 2, 1'b1);   // sparse acks, heavy backpressure
        t_idle_normal();
        t_stray_ack();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule